// File: doc/BRIEF.md
# UART Receive Deserialiser with Sticky Error Status

This block turns an asynchronous serial input into parallel characters. A free-running 16x oversampling strobe paces it: each falling edge on the line is confirmed at mid-bit, the data bits are taken at their centres, and an optional parity bit and the first stop bit are checked. Every completed character leaves as one word that carries the data and four error flags. The block pushes that word into an external receive FIFO. The FIFO storage and the oversampling strobe generator sit outside this block.

Next to the datapath the block keeps a four-bit sticky error status. Overrun sets its bit in the cycle after a character arrives at a full FIFO. The framing, parity and break bits are set from the flags of each character that the system reads from the FIFO. Any write strobe clears all four bits. The receive DMA request drops once an error occurs and stays low until the status is cleared. A receive-timeout event fires when characters wait in the FIFO and the line has shown no new start bit for 32 bit periods.

Top module: `uart_rx_core`

## Requirements
- R1: With 8 data bits and no parity, a frame is pushed as one word whose bits [7:0] are the data, sent LSB first, and whose bits [11:8] are all zero when the frame is clean.
- R2: `word_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits above the selected length are zero in the pushed word.
- R3: With `par_en` set, the parity bit follows the data. With `par_stick` clear, even parity (`par_even`=1) expects the XOR of the data bits and odd parity expects its inverse. With `par_stick` set, the expected bit is the inverse of `par_even`. A mismatch sets word bit 9.
- R4: A frame whose first stop bit samples low, but which is not a break, is pushed with word bit 8 (framing) set.
- R5: A frame in which the start, data, parity and stop samples are all low is a break. It is pushed as data zero with word bit 10 set and bits 8 and 9 clear, and no new frame starts until the line returns high.
- R6: A character that completes while `fifo_full` is high is not pushed. It sets `err_status[3]` in the next cycle and pulses `err_event`. The next pushed character carries word bit 11.
- R7: A read strobe `rd_en` ORs `rd_flags` (framing at bit 0, parity at bit 1, break at bit 2) into `err_status[2:0]`.
- R8: A `reg_wr` strobe clears all of `err_status` in the next cycle. A set that arrives in the same cycle wins.
- R9: `rx_dma_req` is high when `dma_en` is set, `fifo_count` is non-zero and no error has occurred since the last `reg_wr`. Any `err_event` holds it low until the next `reg_wr`.
- R10: `timeout_event` pulses once when `fifo_count` is non-zero and the receiver has stayed idle for 32 bit periods (512 strobes). It does not fire while the FIFO is empty.
- R11: A low on the line that has ended by the mid-bit confirmation sample starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select; with stick, 1 selects a zero bit |
| par_stick | input | 1 | Fixed parity bit mode |
| fifo_full | input | 1 | External FIFO is full |
| fifo_count | input | 5 | External FIFO fill level |
| rd_en | input | 1 | A character was read from the FIFO |
| rd_flags | input | 3 | Break, parity, framing flags of the read character |
| reg_wr | input | 1 | Write strobe that clears the error status |
| dma_en | input | 1 | Receive DMA enable |
| push | output | 1 | Write strobe into the FIFO |
| push_word | output | 12 | Overrun, break, parity, framing flags over the data |
| err_status | output | 4 | Sticky status: overrun, break, parity, framing |
| err_event | output | 1 | Pulse on an erroneous push or an overrun |
| timeout_event | output | 1 | Receive-timeout pulse |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench sends a 5-bit frame, because a receiver that ignores `word_len` would read the stop and idle bits as data. It covers each parity flavour, including stick parity with both polarities, because an inverted expectation would flag good frames. A break and a plain framing error are sent one after the other: a design that mixed them up would set the wrong flag, or would restart on the held-low line and push garbage. The overrun test looks at the status bit before any read, and at the flag on the following character. The timeout test samples just before and just after the 32-bit window, since an off-by-some counter fires in the wrong one.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_HOLD
   } rx_state_e;

   localparam int FLG_FRAME = 0;
   localparam int FLG_PAR   = 1;
   localparam int FLG_BRK   = 2;
   localparam int FLG_OVR   = 3;
   localparam int FLG_W     = 4;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else if (STAGES == 1) sh_q <= d_in;
            else sh_q <= {sh_q[STAGES-2:0], d_in};
         end
         assign d_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx,
   input  logic              tick,
   input  logic [1:0]        word_len,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              par_stick,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              fe,
   output logic              pe,
   output logic              be,
   output logic              idle
);
   localparam int CW    = $clog2(OVS);
   localparam int IW    = $clog2(DATA_W);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     bit_idx;
   logic [DATA_W-1:0] shreg;
   logic              par_acc, par_bit, any_high;
   logic [IW-1:0]     last_idx;
   logic              exp_par, brk_now;

   assign last_idx = IW'(4) + IW'(word_len);
   assign exp_par  = par_stick ? ~par_even : (par_even ? par_acc : ~par_acc);
   assign brk_now  = !any_high && !rx;
   assign idle     = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  cnt <= '0;  bit_idx <= '0;  shreg <= '0;
         par_acc <= 1'b0;   par_bit <= 1'b0;  any_high <= 1'b0;
         done <= 1'b0;  data <= '0;  fe <= 1'b0;  pe <= 1'b0;  be <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: if (!rx) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
               ST_START: if (cnt == MID) begin
                  cnt <= '0;  bit_idx <= '0;  shreg <= '0;
                  par_acc <= 1'b0;  any_high <= 1'b0;
                  state <= rx ? ST_IDLE : ST_DATA;
               end else cnt <= cnt + 1'b1;
               ST_DATA: if (cnt == LAST) begin
                  cnt <= '0;
                  shreg[bit_idx] <= rx;
                  par_acc  <= par_acc ^ rx;
                  any_high <= any_high | rx;
                  if (bit_idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                  else bit_idx <= bit_idx + 1'b1;
               end else cnt <= cnt + 1'b1;
               ST_PAR: if (cnt == LAST) begin
                  cnt <= '0;
                  par_bit  <= rx;
                  any_high <= any_high | rx;
                  state    <= ST_STOP;
               end else cnt <= cnt + 1'b1;
               ST_STOP: if (cnt == LAST) begin
                  cnt  <= '0;
                  done <= 1'b1;
                  data <= brk_now ? '0 : shreg;
                  be   <= brk_now;
                  fe   <= !rx && !brk_now;
                  pe   <= par_en && (par_bit != exp_par) && !brk_now;
                  state <= rx ? ST_IDLE : ST_HOLD;
               end else cnt <= cnt + 1'b1;
               ST_HOLD: if (rx) state <= ST_IDLE;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_errs.sv
module uart_rx_errs
   import uart_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ovr_hit,
   input  logic              rd_en,
   input  logic [2:0]        rd_flags,
   input  logic              reg_wr,
   input  logic              err_event,
   output logic [FLG_W-1:0]  status,
   output logic              halted
);
   logic [FLG_W-1:0] sets;

   always_comb begin
      sets = '0;
      sets[FLG_OVR] = ovr_hit;
      if (rd_en) begin
         sets[FLG_FRAME] = rd_flags[0];
         sets[FLG_PAR]   = rd_flags[1];
         sets[FLG_BRK]   = rd_flags[2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         halted <= 1'b0;
      end else begin
         status <= (reg_wr ? '0 : status) | sets;
         halted <= (reg_wr ? 1'b0 : halted) | err_event;
      end
   end
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
   parameter int OVS     = 16,
   parameter int TO_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic armed,
   output logic fire
);
   localparam int LIMIT = OVS * TO_BITS;
   localparam int CW    = $clog2(LIMIT);

   logic [CW-1:0] cnt;
   logic          spent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;  spent <= 1'b0;  fire <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (!armed) begin
            cnt   <= '0;
            spent <= 1'b0;
         end else if (tick && !spent) begin
            if (cnt == CW'(LIMIT - 1)) begin
               fire  <= 1'b1;
               spent <= 1'b1;
            end else cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 5,
   parameter int TO_BITS     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_in,
   input  logic                    tick16,
   input  logic [1:0]              word_len,
   input  logic                    par_en,
   input  logic                    par_even,
   input  logic                    par_stick,
   input  logic                    fifo_full,
   input  logic [CNT_W-1:0]        fifo_count,
   input  logic                    rd_en,
   input  logic [2:0]              rd_flags,
   input  logic                    reg_wr,
   input  logic                    dma_en,
   output logic                    push,
   output logic [DATA_W+FLG_W-1:0] push_word,
   output logic [FLG_W-1:0]        err_status,
   output logic                    err_event,
   output logic                    timeout_event,
   output logic                    rx_dma_req
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("uart_rx_core: DATA_W must be 8");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_rx_core: OVS must be even and at least 4");
      end
      if (TO_BITS < 1) begin : g_bad_to
         $error("uart_rx_core: TO_BITS must be positive");
      end
   endgenerate

   logic              rx_s, f_done, f_fe, f_pe, f_be, line_idle;
   logic [DATA_W-1:0] f_data;
   logic              ovr_hit, ovr_pend, halted, fifo_nz;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rx_s)
   );

   uart_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(tick16),
      .word_len(word_len), .par_en(par_en), .par_even(par_even),
      .par_stick(par_stick), .done(f_done), .data(f_data),
      .fe(f_fe), .pe(f_pe), .be(f_be), .idle(line_idle)
   );

   assign push      = f_done && !fifo_full;
   assign ovr_hit   = f_done && fifo_full;
   assign push_word = {ovr_pend, f_be, f_pe, f_fe, f_data};
   assign err_event = ovr_hit || (push && (f_fe || f_pe || f_be));
   assign fifo_nz   = (fifo_count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovr_pend <= 1'b0;
      else if (ovr_hit) ovr_pend <= 1'b1;
      else if (push) ovr_pend <= 1'b0;
   end

   uart_rx_errs u_errs (
      .clk(clk), .rst_n(rst_n), .ovr_hit(ovr_hit), .rd_en(rd_en),
      .rd_flags(rd_flags), .reg_wr(reg_wr), .err_event(err_event),
      .status(err_status), .halted(halted)
   );

   uart_rx_timer #(.OVS(OVS), .TO_BITS(TO_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick16),
      .armed(fifo_nz && line_idle), .fire(timeout_event)
   );

   assign rx_dma_req = dma_en && fifo_nz && !halted;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               push,
   input logic [DATA_W+3:0]  push_word,
   input logic               fifo_full,
   input logic [CNT_W-1:0]   fifo_count,
   input logic               ovr_hit,
   input logic               rd_en,
   input logic               reg_wr,
   input logic [3:0]         err_status,
   input logic               err_event,
   input logic               timeout_event,
   input logic               rx_dma_req
);
   assert_no_push_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !push);

   assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_hit |=> err_status[3]);

   assert_break_zero_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && push_word[DATA_W+2]) |-> (push_word[DATA_W-1:0] == '0 && !push_word[DATA_W]));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !ovr_hit && !rd_en) |=> (err_status == 4'b0000));

   assert_dma_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_event && !reg_wr) |=> !rx_dma_req);

   assert_timeout_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_event |-> ($past(fifo_count) != '0));
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
   .fifo_full(fifo_full), .fifo_count(fifo_count), .ovr_hit(ovr_hit),
   .rd_en(rd_en), .reg_wr(reg_wr), .err_status(err_status),
   .err_event(err_event), .timeout_event(timeout_event), .rx_dma_req(rx_dma_req)
);

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;
   localparam int BITC = 32;  // cycles per bit: 16 strobes, one every 2 cycles

   logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, tick16 = 1'b0;
   logic [1:0] word_len = 2'd3;
   logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
   logic fifo_full = 1'b0;
   logic [4:0] fifo_count = '0;
   logic rd_en = 1'b0, reg_wr = 1'b0, dma_en = 1'b0;
   logic [2:0] rd_flags = '0;
   logic push, err_event, timeout_event, rx_dma_req;
   logic [11:0] push_word;
   logic [3:0] err_status;

   int n_chk = 0, n_bad = 0;
   int push_cnt = 0, ev_cnt = 0, to_cnt = 0;
   logic [11:0] last_word = '0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   uart_rx_core uut (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
      .word_len(word_len), .par_en(par_en), .par_even(par_even),
      .par_stick(par_stick), .fifo_full(fifo_full), .fifo_count(fifo_count),
      .rd_en(rd_en), .rd_flags(rd_flags), .reg_wr(reg_wr), .dma_en(dma_en),
      .push(push), .push_word(push_word), .err_status(err_status),
      .err_event(err_event), .timeout_event(timeout_event), .rx_dma_req(rx_dma_req)
   );

   initial begin
      forever begin
         @(negedge clk);
         tick16 = ~tick16;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (push) begin push_cnt++; last_word = push_word; end
         if (err_event) ev_cnt++;
         if (timeout_event) to_cnt++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rx_in = v;
      repeat (BITC) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input int nb, input logic use_par,
                            input logic pbit, input logic stopb);
      hold_bit(1'b0);
      for (int i = 0; i < nb; i++) hold_bit(d[i]);
      if (use_par) hold_bit(pbit);
      hold_bit(stopb);
      rx_in = 1'b1;
      repeat (2 * BITC) @(negedge clk);
   endtask

   task automatic clear_status();
      @(negedge clk); reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 reset push", push, 0);
      check("R8 reset status", err_status, 0);
      check("R9 reset dma", rx_dma_req, 0);
      check("R10 reset timeout", timeout_event, 0);
   endtask

   task automatic t_basic();
      int p0 = push_cnt;
      word_len = 2'd3; par_en = 1'b0;
      send_char(8'hA5, 8, 0, 0, 1);
      check("R1 push count", push_cnt - p0, 1);
      check("R1 word A5", last_word, 12'h0A5);
      send_char(8'h3C, 8, 0, 0, 1);
      check("R1 word 3C", last_word, 12'h03C);
   endtask

   task automatic t_short();
      word_len = 2'd0;
      send_char(8'h15, 5, 0, 0, 1);
      check("R2 5-bit word", last_word, 12'h015);
      word_len = 2'd2;
      send_char(8'h7F, 7, 0, 0, 1);
      check("R2 7-bit word", last_word, 12'h07F);
      word_len = 2'd3;
   endtask

   task automatic t_parity();
      par_en = 1'b1; par_stick = 1'b0; par_even = 1'b1;
      send_char(8'hA5, 8, 1, 1'b0, 1);
      check("R3 even good", last_word, 12'h0A5);
      send_char(8'hA5, 8, 1, 1'b1, 1);
      check("R3 even bad", last_word, 12'h2A5);
      par_even = 1'b0;
      send_char(8'h07, 8, 1, 1'b0, 1);
      check("R3 odd good", last_word, 12'h007);
      par_stick = 1'b1; par_even = 1'b0;
      send_char(8'h01, 8, 1, 1'b1, 1);
      check("R3 stick one good", last_word, 12'h001);
      par_even = 1'b1;
      send_char(8'h01, 8, 1, 1'b1, 1);
      check("R3 stick zero bad", last_word, 12'h201);
      par_en = 1'b0; par_stick = 1'b0;
      clear_status();
   endtask

   task automatic t_framing();
      int p0 = push_cnt;
      send_char(8'h3C, 8, 0, 0, 0);
      check("R4 framing word", last_word, 12'h13C);
      send_char(8'h5A, 8, 0, 0, 1);
      check("R4 one push each", push_cnt - p0, 2);
      check("R4 recovers", last_word, 12'h05A);
   endtask

   task automatic t_break();
      int p0 = push_cnt;
      for (int i = 0; i < 14; i++) hold_bit(1'b0);
      rx_in = 1'b1;
      repeat (2 * BITC) @(negedge clk);
      check("R5 break single push", push_cnt - p0, 1);
      check("R5 break word", last_word, 12'h400);
      clear_status();
   endtask

   task automatic t_overrun();
      int p0 = push_cnt, e0 = ev_cnt;
      fifo_full = 1'b1;
      send_char(8'h11, 8, 0, 0, 1);
      check("R6 no push when full", push_cnt - p0, 0);
      check("R6 status set at once", err_status, 4'b1000);
      check("R6 event", ev_cnt - e0, 1);
      fifo_full = 1'b0;
      send_char(8'h22, 8, 0, 0, 1);
      check("R6 flag on next char", last_word, 12'h822);
      send_char(8'h33, 8, 0, 0, 1);
      check("R6 flag once", last_word, 12'h033);
   endtask

   task automatic t_readflags();
      clear_status();
      check("R8 cleared", err_status, 0);
      @(negedge clk); rd_en = 1'b1; rd_flags = 3'b010;
      @(negedge clk); rd_en = 1'b0; rd_flags = 3'b111;
      @(negedge clk);
      check("R7 parity from read", err_status, 4'b0010);
      rd_en = 1'b1; rd_flags = 3'b101;
      @(negedge clk); rd_en = 1'b0;
      @(negedge clk);
      check("R7 accumulate", err_status, 4'b0111);
      clear_status();
      check("R8 write clears all", err_status, 0);
   endtask

   task automatic t_dma();
      dma_en = 1'b1; fifo_count = 5'd2;
      @(negedge clk);
      check("R9 request", rx_dma_req, 1);
      send_char(8'h44, 8, 0, 0, 0);
      check("R9 halted after error", rx_dma_req, 0);
      clear_status();
      check("R9 resumes after clear", rx_dma_req, 1);
      dma_en = 1'b0; fifo_count = 5'd0;
      @(negedge clk);
   endtask

   task automatic t_glitch();
      int p0 = push_cnt;
      rx_in = 1'b0;
      repeat (6) @(negedge clk);
      rx_in = 1'b1;
      repeat (3 * BITC) @(negedge clk);
      check("R11 glitch ignored", push_cnt - p0, 0);
   endtask

   task automatic t_timeout();
      int t0 = to_cnt;
      fifo_count = 5'd0;
      repeat (40 * BITC) @(negedge clk);
      check("R10 none when empty", to_cnt - t0, 0);
      fifo_count = 5'd3;
      repeat (30 * BITC) @(negedge clk);
      check("R10 not early", to_cnt - t0, 0);
      repeat (4 * BITC) @(negedge clk);
      check("R10 fires", to_cnt - t0, 1);
      repeat (40 * BITC) @(negedge clk);
      check("R10 fires once", to_cnt - t0, 1);
      fifo_count = 5'd0;
      @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_basic();
      t_short();
      t_parity();
      t_framing();
      clear_status();
      t_break();
      t_overrun();
      t_readflags();
      t_dma();
      t_glitch();
      t_timeout();
      done_flag = 1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (150000) @(negedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule